// File: doc/BRIEF.md
# SDRAM Bank State Timing Tracker

This block sits beside the command issue stage of a memory controller for a four-bank double-data-rate SDRAM. It keeps track of which banks have a row open. For every command the controller presents, it says in the same cycle whether that command may be issued now. The controller issues a command only when the block marks it legal. A command that is not legal is held back and presented again later.

Each bank has its own set of countdowns:

- activate to column access;
- activate to precharge (row-active minimum);
- activate to activate (row-cycle minimum);
- precharge period.

Address bit 10 selects auto-precharge on a column access. On a precharge it selects all banks. An auto-precharge closes the bank by itself once its row-active minimum and the burst have both run out. The timing limits are nanosecond values. They become cycle counts by rounding up at the configured clock period.

Top module: `sdr_bank_tracker`

## Requirements
- R1: After reset every bank reads closed on `bank_open`, and an activate to any bank is legal in the first cycle after reset.
- R2: `cmd_op` encodes 0 no-op, 1 activate, 2 read, 3 write, 4 precharge and 5 refresh. Codes 6 and 7 are reserved: they are always illegal and have no effect. A no-op is always legal. With `cmd_valid` low, both `cmd_legal` and `cmd_illegal` are low.
- R3: An activate presented in cycle c is legal only when all of these hold:
  - the bank is closed;
  - at least tRP cycles have passed since the cycle in which the bank closed;
  - at least tRC cycles have passed since its previous activate.

  An accepted activate opens the bank.
- R4: A read or write is legal only when all of these hold:
  - the bank is open;
  - at least tRCD cycles have passed since its activate;
  - no auto-precharge is pending on that bank.
- R5: A precharge with `cmd_a10`=0 addressed to a closed bank is legal and has no effect, even while that bank's tRP is still running. Addressed to an open bank, it is legal only when both of these hold:
  - at least tRAS cycles have passed since the activate;
  - no auto-precharge is pending.

  An accepted precharge closes the bank.
- R6: A precharge with `cmd_a10`=1 ignores `cmd_bank`. It is legal only when every bank would accept a single precharge under R5, and it then closes every open bank.
- R7: A read or write with `cmd_a10`=1 sets a pending auto-precharge on its bank. The bank closes in the first cycle c in which both of these hold:
  - c minus the activate cycle is at least tRAS;
  - c minus the access cycle is at least BURST_CYC.

  `bank_open` drops in cycle c+1, and tRP counts from cycle c.
- R8: A refresh is legal only when every bank is closed and its tRP has elapsed. A refresh changes no bank state.
- R9: When a valid command is not legal, `cmd_illegal` is high, `cmd_legal` is low, and no bank state changes.
- R10: Each limit is the nanosecond value divided by the clock period, rounded up. At the default 8 ns period the limits are tRCD=2, tRP=2, tRAS=6 and tRC=8 cycles, and BURST_CYC defaults to 2.
- R11: `bank_open` for a bank is high from the cycle after its accepted activate through the cycle in which it closes. It is low in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Command code (R2) |
| cmd_bank | input | 2 | Target bank |
| cmd_a10 | input | 1 | Auto-precharge on read/write, all-bank select on precharge |
| cmd_legal | output | 1 | Presented command may issue now and is taken |
| cmd_illegal | output | 1 | Presented command would break a limit and is dropped |
| bank_open | output | 4 | One bit per bank, high while a row is open |

## Verification
Directed sequences place commands one cycle before and exactly at each limit. This separates an off-by-one in any countdown from a correct one. Other directed cases aim a precharge at an idle bank and a refresh at an open bank, so that a skipped no-effect path is told apart from a wrongly applied one. An auto-precharge access is followed by no-ops and then by activates at the edge of its tRP, which shows whether the closing cycle honours both the row-active time and the burst end. A long seeded random stream mixes all codes, including reserved ones, all-bank precharges and dropped commands. It is compared every cycle with a cycle-stamped reference model, which exposes interactions between banks and between auto-precharge and explicit commands.

// File: rtl/sdr_trk_pkg.sv
package sdr_trk_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_PRE  = 3'd4,
        OP_REF  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } cmd_op_e;

    // Per-bank control strobes for an accepted command
    typedef struct packed {
        logic act;
        logic rdwr;
        logic ap;
        logic pre;
    } bank_ctl_t;

    // Per-bank readiness toward the command judge
    typedef struct packed {
        logic act_ok;
        logic rw_ok;
        logic pre_ok;
        logic rest;
    } bank_sts_t;

    // Nanosecond limit (in ps) to whole cycles, rounded up
    function automatic int ps_to_cyc(input int ps, input int clk_ps);
        return (ps + clk_ps - 1) / clk_ps;
    endfunction

    // Counter preload so that zero is reached n cycles after the event
    function automatic int preload(input int n);
        return (n > 0) ? n - 1 : 0;
    endfunction

endpackage

// File: rtl/sat_down_cnt.sv
module sat_down_cnt #(
    parameter int LOAD = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic is_zero
);
    localparam int W = (LOAD < 1) ? 1 : $clog2(LOAD + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= W'(LOAD);
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign is_zero = (cnt == '0);

endmodule

// File: rtl/sdr_bank_timer.sv
module sdr_bank_timer
    import sdr_trk_pkg::*;
#(
    parameter int RCD_N   = 2,
    parameter int RP_N    = 2,
    parameter int RAS_N   = 6,
    parameter int RC_N    = 8,
    parameter int BURST_N = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  bank_ctl_t ctl,
    output logic      is_open,
    output bank_sts_t sts
);
    localparam int RCD_L   = preload(RCD_N);
    localparam int RP_L    = preload(RP_N);
    localparam int RAS_L   = preload(RAS_N);
    localparam int RC_L    = preload(RC_N);
    localparam int BURST_L = preload(BURST_N);

    logic open_q, ap_q;
    logic rcd_z, rp_z, ras_z, rc_z, bst_z;
    logic ap_fire, closing;

    sat_down_cnt #(.LOAD(RCD_L))   u_rcd (.clk(clk), .rst(rst), .load(ctl.act),  .is_zero(rcd_z));
    sat_down_cnt #(.LOAD(RAS_L))   u_ras (.clk(clk), .rst(rst), .load(ctl.act),  .is_zero(ras_z));
    sat_down_cnt #(.LOAD(RC_L))    u_rc  (.clk(clk), .rst(rst), .load(ctl.act),  .is_zero(rc_z));
    sat_down_cnt #(.LOAD(RP_L))    u_rp  (.clk(clk), .rst(rst), .load(closing),  .is_zero(rp_z));
    sat_down_cnt #(.LOAD(BURST_L)) u_bst (.clk(clk), .rst(rst), .load(ctl.rdwr), .is_zero(bst_z));

    assign ap_fire = ap_q && ras_z && bst_z;
    assign closing = (ctl.pre && open_q) || ap_fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            ap_q   <= 1'b0;
        end else begin
            if (ctl.act)
                open_q <= 1'b1;
            else if (closing)
                open_q <= 1'b0;
            if (ctl.rdwr && ctl.ap)
                ap_q <= 1'b1;
            else if (ap_fire)
                ap_q <= 1'b0;
        end
    end

    assign is_open    = open_q;
    assign sts.act_ok = !open_q && rp_z && rc_z;
    assign sts.rw_ok  = open_q && rcd_z && !ap_q;
    assign sts.pre_ok = !open_q || (ras_z && !ap_q);
    assign sts.rest   = !open_q && rp_z;

    // Cycles since the last activate, saturating; used only by the checks
    localparam int SW = $clog2(RC_N + RCD_N + 2);
    logic [SW-1:0] since_act;
    always_ff @(posedge clk) begin
        if (rst)
            since_act <= '1;
        else if (ctl.act)
            since_act <= SW'(1);
        else if (since_act != '1)
            since_act <= since_act + SW'(1);
    end

    // R3: activate only to a closed bank
    a_r3_act_when_closed: assert property (@(posedge clk) disable iff (rst)
        ctl.act |-> !open_q);
    // R3: row-cycle spacing between activates
    a_r3_row_cycle: assert property (@(posedge clk) disable iff (rst)
        (ctl.act && since_act != '1) |-> (int'(since_act) >= RC_N));
    // R4: column access waits tRCD after activate
    a_r4_rcd_spacing: assert property (@(posedge clk) disable iff (rst)
        ctl.rdwr |-> (int'(since_act) >= RCD_N));
    // R7: a pending auto-precharge belongs to an open bank
    a_r7_ap_on_open: assert property (@(posedge clk) disable iff (rst)
        ap_q |-> open_q);
    // R11: bank opens only after an accepted activate
    a_r11_open_source: assert property (@(posedge clk) disable iff (rst)
        $rose(open_q) |-> $past(ctl.act));

endmodule

// File: rtl/sdr_cmd_judge.sv
module sdr_cmd_judge
    import sdr_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2
) (
    input  logic                        cmd_valid,
    input  logic [2:0]                  cmd_op,
    input  logic [BA_W-1:0]             cmd_bank,
    input  logic                        cmd_a10,
    input  bank_sts_t [NUM_BANKS-1:0]   sts,
    output logic                        ok,
    output bank_ctl_t [NUM_BANKS-1:0]   ctl
);
    cmd_op_e op;
    logic all_pre_ok, all_rest, accept;

    assign op = cmd_op_e'(cmd_op);

    always_comb begin
        all_pre_ok = 1'b1;
        all_rest   = 1'b1;
        for (int b = 0; b < NUM_BANKS; b++) begin
            all_pre_ok = all_pre_ok && sts[b].pre_ok;
            all_rest   = all_rest && sts[b].rest;
        end
    end

    always_comb begin
        unique case (op)
            OP_NOP:        ok = 1'b1;
            OP_ACT:        ok = sts[cmd_bank].act_ok;
            OP_RD, OP_WR:  ok = sts[cmd_bank].rw_ok;
            OP_PRE:        ok = cmd_a10 ? all_pre_ok : sts[cmd_bank].pre_ok;
            OP_REF:        ok = all_rest;
            default:       ok = 1'b0;
        endcase
    end

    assign accept = cmd_valid && ok;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_ctl
        logic hit;
        assign hit          = (cmd_bank == BA_W'(b));
        assign ctl[b].act   = accept && (op == OP_ACT) && hit;
        assign ctl[b].rdwr  = accept && (op == OP_RD || op == OP_WR) && hit;
        assign ctl[b].ap    = cmd_a10;
        assign ctl[b].pre   = accept && (op == OP_PRE) && (cmd_a10 || hit);
    end

endmodule

// File: rtl/sdr_bank_tracker.sv
module sdr_bank_tracker
    import sdr_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int CLK_PS    = 8000,
    parameter int RCD_PS    = 15000,
    parameter int RP_PS     = 15000,
    parameter int RAS_PS    = 45000,
    parameter int RC_PS     = 60000,
    parameter int BURST_CYC = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    input  logic [1:0]           cmd_bank,
    input  logic                 cmd_a10,
    output logic                 cmd_legal,
    output logic                 cmd_illegal,
    output logic [NUM_BANKS-1:0] bank_open
);
    localparam int BA_W   = $clog2(NUM_BANKS);
    // R10: limits in whole cycles, rounded up
    localparam int RCD_N  = ps_to_cyc(RCD_PS, CLK_PS);
    localparam int RP_N   = ps_to_cyc(RP_PS, CLK_PS);
    localparam int RAS_N  = ps_to_cyc(RAS_PS, CLK_PS);
    localparam int RC_N   = ps_to_cyc(RC_PS, CLK_PS);

    bank_sts_t [NUM_BANKS-1:0] sts;
    bank_ctl_t [NUM_BANKS-1:0] ctl;
    logic ok;

    sdr_cmd_judge #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_judge (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_bank  (cmd_bank[BA_W-1:0]),
        .cmd_a10   (cmd_a10),
        .sts       (sts),
        .ok        (ok),
        .ctl       (ctl)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdr_bank_timer #(
            .RCD_N(RCD_N), .RP_N(RP_N), .RAS_N(RAS_N),
            .RC_N(RC_N), .BURST_N(BURST_CYC)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .ctl     (ctl[b]),
            .is_open (bank_open[b]),
            .sts     (sts[b])
        );
    end

    assign cmd_legal   = cmd_valid && ok;
    assign cmd_illegal = cmd_valid && !ok;

    // R4: an accepted column access targets an open bank
    a_r4_access_open: assert property (@(posedge clk) disable iff (rst)
        (cmd_legal && (cmd_op == OP_RD || cmd_op == OP_WR)) |-> bank_open[cmd_bank[BA_W-1:0]]);
    // R8: accepted refresh only with every bank closed
    a_r8_refresh_idle: assert property (@(posedge clk) disable iff (rst)
        (cmd_legal && cmd_op == OP_REF) |-> (bank_open == '0));
    // R9: a dropped command opens no bank
    a_r9_drop_no_open: assert property (@(posedge clk) disable iff (rst)
        cmd_illegal |=> ((bank_open & ~$past(bank_open)) == '0));
    // R2: reserved codes are never accepted
    a_r2_reserved: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op[2:1] == 2'b11) |-> !cmd_legal);

endmodule

// File: tb/sim_sdr_bank_tracker.sv
`timescale 1ns/1ps
module sim_sdr_bank_tracker;

    // R10 cycle limits at 8 ns
    localparam int T_RCD = 2, T_RP = 2, T_RAS = 6, T_RC = 8, T_BST = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic cmd_a10 = 1'b0;
    logic cmd_legal, cmd_illegal;
    logic [3:0] bank_open;

    always #4 clk = ~clk;

    sdr_bank_tracker u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_a10(cmd_a10), .cmd_legal(cmd_legal),
        .cmd_illegal(cmd_illegal), .bank_open(bank_open)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit m_open[4], m_ap[4];
    int t_act[4], t_close[4], t_rw[4];

    task automatic check(input bit good, input string tag, input int act, input int exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    function automatic bit exp_ok(input int op, input int b, input bit a10);
        bit r;
        case (op)
            0: r = 1;
            1: r = !m_open[b] && (cyc - t_close[b] >= T_RP) && (cyc - t_act[b] >= T_RC);
            2, 3: r = m_open[b] && (cyc - t_act[b] >= T_RCD) && !m_ap[b];
            4: begin
                if (!a10) r = !m_open[b] || ((cyc - t_act[b] >= T_RAS) && !m_ap[b]);
                else begin
                    r = 1;
                    for (int k = 0; k < 4; k++)
                        if (m_open[k] && !((cyc - t_act[k] >= T_RAS) && !m_ap[k])) r = 0;
                end
            end
            5: begin
                r = 1;
                for (int k = 0; k < 4; k++)
                    if (m_open[k] || (cyc - t_close[k] < T_RP)) r = 0;
            end
            default: r = 0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input int op, input bit a10, input bit v);
        if (!v || op == 0 || op > 5) return "R2";
        case (op)
            1: return "R3";
            2, 3: return "R4";
            4: return a10 ? "R6" : "R5";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [3:0] model_vec();
        logic [3:0] m;
        for (int k = 0; k < 4; k++) m[k] = m_open[k];
        return m;
    endfunction

    task automatic step(input int op, input int b, input bit a10, input bit v, input string tag);
        bit e;
        @(negedge clk);
        cmd_valid = v; cmd_op = op[2:0]; cmd_bank = b[1:0]; cmd_a10 = a10;
        #1;
        e = v && exp_ok(op, b, a10);
        check(cmd_legal === e, tag, int'(cmd_legal), int'(e));
        check(cmd_illegal === (v && !e), (v && !e) ? "R9" : tag, int'(cmd_illegal), int'(v && !e));
        check(bank_open === model_vec(), "R11", int'(bank_open), int'(model_vec()));
        @(posedge clk);
        // R7: auto-precharge closes when tRAS and burst end are both met
        for (int k = 0; k < 4; k++)
            if (m_ap[k] && (cyc - t_act[k] >= T_RAS) && (cyc - t_rw[k] >= T_BST)) begin
                m_open[k] = 0; m_ap[k] = 0; t_close[k] = cyc;
            end
        if (e) begin
            case (op)
                1: begin m_open[b] = 1; t_act[b] = cyc; end
                2, 3: begin t_rw[b] = cyc; if (a10) m_ap[b] = 1; end
                4: for (int k = 0; k < 4; k++)
                       if ((a10 || k == b) && m_open[k]) begin
                           m_open[k] = 0; t_close[k] = cyc;
                       end
                default: ;
            endcase
        end
        cyc++;
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 1, "R2");
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) begin
            m_open[k] = 0; m_ap[k] = 0;
            t_act[k] = -1000; t_close[k] = -1000; t_rw[k] = -1000;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(bank_open === 4'b0000, "R1", int'(bank_open), 0);

        // Directed corner cases
        step(1, 0, 0, 1, "R1");       // c0 activate bank 0
        step(2, 0, 0, 1, "R10");      // c1 read one cycle early
        step(2, 0, 0, 1, "R10");      // c2 read at tRCD
        step(4, 0, 0, 1, "R5");       // c3 precharge before tRAS
        step(4, 1, 0, 1, "R5");       // c4 precharge idle bank, no effect
        step(0, 0, 0, 1, "R2");       // c5
        step(4, 0, 0, 1, "R5");       // c6 precharge at tRAS
        step(1, 0, 0, 1, "R3");       // c7 activate inside tRP
        step(1, 0, 0, 1, "R3");       // c8 activate at tRP and tRC
        step(5, 0, 0, 1, "R8");       // c9 refresh with bank open
        step(1, 2, 0, 1, "R3");       // c10 activate bank 2
        step(0, 0, 0, 1, "R2");       // c11
        step(3, 2, 1, 1, "R7");       // c12 write with auto-precharge
        step(2, 2, 0, 1, "R7");       // c13 access while auto-precharge pends
        step(4, 2, 0, 1, "R7");       // c14 precharge while pending
        step(0, 0, 0, 1, "R7");       // c15
        step(0, 0, 0, 1, "R7");       // c16 closes here
        step(1, 2, 0, 1, "R7");       // c17 inside tRP after auto close
        step(1, 2, 0, 1, "R7");       // c18 legal again
        nops(6);
        step(4, 3, 1, 1, "R6");       // all-bank precharge
        step(5, 0, 0, 1, "R8");       // refresh inside tRP
        step(5, 0, 0, 1, "R8");       // refresh after tRP
        step(6, 1, 0, 1, "R2");       // reserved code
        step(7, 1, 1, 1, "R2");
        step(1, 1, 0, 0, "R2");       // not valid: no effect
        step(2, 1, 0, 1, "R11");      // bank 1 still closed

        // Seeded random stream
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            int r, op, b;
            bit a10, v;
            r = $urandom % 16;
            b = $urandom % 4;
            a10 = ($urandom % 4) == 0;
            v = 1;
            if (r < 4) op = 1;
            else if (r < 7) op = 2;
            else if (r < 10) op = 3;
            else if (r < 12) op = 4;
            else if (r == 12) op = 5;
            else if (r == 13) op = 0;
            else if (r == 14) op = 6 + ($urandom % 2);
            else begin op = $urandom % 6; v = 0; end
            step(op, b, a10, v, tag_of(op, a10, v));
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule